// File: doc/BRIEF.md
# Median-Average Sample Filter

This block cleans up noisy converter readings before they reach the host. It takes a burst of seven samples on a valid/ready input stream and puts them into order. It then emits the integer mean of the three central ranks as a single result on a valid/ready output stream. Outliers at either end of the burst are thrown away. The surviving middle values are smoothed, so one spike cannot pull the result. The same filter serves every input channel: position, temperature and auxiliary. Narrower 8-bit conversions are zero-extended by the caller and go through the same path.

Ordering is done in place over several clock cycles by an odd-even transposition network. Each cycle performs one compare-exchange pass. The number of cycles is fixed, so the result always appears at the same distance from the seventh sample, well within a 19-cycle budget.

A bypass input lets a single sample pass straight to the output when a burst begins. The filter is used whenever that input is low.

Top module: `median_avg_filter`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: In filter mode, no result is offered until exactly seven samples have been accepted. After six accepted samples, `out_valid` stays low and `in_ready` stays high.
- R3: The result equals the sum of the 3rd, 4th and 5th smallest of the seven accepted samples, divided by three.
- R4: Repeated sample values are allowed. The result does not depend on the order in which the samples arrive.
- R5: The division by three truncates toward zero. For example, a middle sum of 5 gives 1 and a middle sum of 4 gives 1.
- R6: If `bypass_i` is high when the first sample of a burst is accepted, that sample is the result. `out_valid` is high in the cycle after the accepting edge, and no further samples are taken for it.
- R7: The level of `bypass_i` while the 2nd to 7th samples of a burst are accepted has no effect on the result.
- R8: `in_ready` is low from the edge that accepts the seventh sample until the edge where the result is accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value. The edge with `out_ready` high removes the result and raises `in_ready` again.
- R10: `out_valid` rises no more than 19 clock cycles after the edge that accepts the seventh sample.
- R11: Full-scale 12-bit samples (4095) are processed without overflow. Seven samples of 4095 give 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (conversion clock domain) |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | Pass-through select, sampled with the first sample of a burst |
| in_valid | input | 1 | Sample present on `in_data` |
| in_data | input | 12 | Sample value, straight binary |
| in_ready | output | 1 | Block can accept a sample |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 12 | Filtered or passed-through result |
| out_ready | input | 1 | Consumer takes the result |

## Verification
A pass-phase counter that is off by one leaves the network partly unsorted. That shows up at `out_data` as a wrong value on the first burst whose samples arrive in descending or shuffled order. The result still comes within the latency bound. A burst counter that is off by one shows up as a result offered after six samples, or as the input stalling after seven. Both are visible within a few cycles of the sixth or seventh sample. An error in the division shows up only for middle sums that are not multiples of three, and for large sums near full scale. For that reason both truncation cases and full-scale bursts are exercised.

// File: rtl/mavf_pkg.sv
package mavf_pkg;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_SORT = 2'd1,
    ST_CALC = 2'd2,
    ST_HOLD = 2'd3
  } mavf_state_e;

  // Reciprocal of three in 16 fractional bits, rounded up.
  localparam logic [15:0] THIRD_Q16 = 16'd21846;

  // Truncating divide by three; exact for sums below 32768.
  function automatic logic [31:0] div3(input logic [31:0] sum);
    logic [47:0] prod;
    prod = 48'(sum) * 48'(THIRD_Q16);
    return prod[47:16];
  endfunction

endpackage

// File: rtl/mavf_cmpx.sv
module mavf_cmpx #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi
);
  logic swap;
  assign swap = a > b;
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;
endmodule

// File: rtl/mavf_sorter.sv
module mavf_sorter #(
  parameter int DW    = 12,
  parameter int NSAMP = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [DW-1:0]              din,
  input  logic                       step,
  input  logic                       phase,
  input  logic                       chk,
  output logic [NSAMP-1:0][DW-1:0]   vals
);
  localparam int NPAIR = NSAMP - 1;

  logic [NPAIR-1:0]          act;
  logic [NPAIR-1:0][DW-1:0]  lo;
  logic [NPAIR-1:0][DW-1:0]  hi;
  logic [NSAMP-1:0][DW-1:0]  nxt;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign act[p] = step && (phase == 1'(p % 2));
    mavf_cmpx #(.DW(DW)) u_cmpx (
      .a (vals[p]),
      .b (vals[p+1]),
      .lo(lo[p]),
      .hi(hi[p])
    );
  end

  for (genvar i = 0; i < NSAMP; i++) begin : g_elem
    if (i == 0) begin : g_first
      assign nxt[i] = act[i] ? lo[i] : vals[i];
    end else if (i == NSAMP - 1) begin : g_last
      assign nxt[i] = act[i-1] ? hi[i-1] : vals[i];
    end else begin : g_mid
      assign nxt[i] = act[i-1] ? hi[i-1] : (act[i] ? lo[i] : vals[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vals <= '0;
    end else if (load) begin
      vals <= {din, vals[NSAMP-1:1]};
    end else if (step) begin
      vals <= nxt;
    end
  end

  // After the last pass, neighbours must be in ascending order.
  for (genvar k = 0; k < NPAIR; k++) begin : g_chk
    p_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chk |-> vals[k] <= vals[k+1]);
  end

endmodule

// File: rtl/median_avg_filter.sv
module median_avg_filter #(
  parameter int DW      = 12,
  parameter int NSAMP   = 7,
  parameter int MAX_LAT = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass_i,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  import mavf_pkg::*;

  localparam int CW  = $clog2(NSAMP);
  localparam int MID = NSAMP / 2;
  localparam int SW  = DW + 2;
  localparam int LW  = $clog2(MAX_LAT + 2);
  localparam logic [CW-1:0] LAST = CW'(NSAMP - 1);

  mavf_state_e              state;
  logic [CW-1:0]            cnt;
  logic [NSAMP-1:0][DW-1:0] vals;
  logic [SW-1:0]            mid_sum;
  logic [DW-1:0]            avg;

  // Named events
  logic take, pass_thru, load, burst_done, sort_step, calc, out_taken;

  assign in_ready   = (state == ST_FILL);
  assign take       = in_valid && in_ready;
  assign pass_thru  = take && (cnt == '0) && bypass_i;
  assign load       = take && !pass_thru;
  assign burst_done = load && (cnt == LAST);
  assign sort_step  = (state == ST_SORT);
  assign calc       = (state == ST_CALC);
  assign out_taken  = out_valid && out_ready;

  assign mid_sum = SW'(vals[MID-1]) + SW'(vals[MID]) + SW'(vals[MID+1]);
  assign avg     = DW'(div3(32'(mid_sum)));

  mavf_sorter #(.DW(DW), .NSAMP(NSAMP)) u_sorter (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .din  (in_data),
    .step (sort_step),
    .phase(cnt[0]),
    .chk  (calc),
    .vals (vals)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      unique case (state)
        ST_FILL: begin
          if (pass_thru) begin
            out_data  <= in_data;
            out_valid <= 1'b1;
            state     <= ST_HOLD;
          end else if (take) begin
            if (cnt == LAST) begin
              cnt   <= '0;
              state <= ST_SORT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_SORT: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_CALC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CALC: begin
          out_data  <= avg;
          out_valid <= 1'b1;
          state     <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_FILL;
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  // Latency window counter for the budget check
  logic [LW-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (burst_done)       lat_cnt <= '0;
    else if (sort_step || calc) lat_cnt <= lat_cnt + 1'b1;
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sort_step || calc) |-> lat_cnt < LW'(MAX_LAT));

  p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_taken |=> (!out_valid && in_ready));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |=> (out_valid && out_data == $past(in_data)));

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !burst_done) |=> (!out_valid && in_ready));

endmodule

// File: tb/median_avg_filter_test.sv
`timescale 1ns/1ps
module median_avg_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass_i = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [11:0] out_data;
  logic        out_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  median_avg_filter uut (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference: sort ascending, mean of ranks 3..5, truncated.
  function automatic int ref_mav(input int s [7]);
    int a [7];
    int t;
    a = s;
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 6 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    return (a[2] + a[3] + a[4]) / 3;
  endfunction

  task automatic push(input int v, input bit byp);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = 12'(v); bypass_i = byp;
    @(negedge clk);
    in_valid = 1'b0; bypass_i = 1'b0;
  endtask

  task automatic collect(input int exp, input string req, input int hold);
    int n = 0;
    while (!out_valid && n < 40) begin @(negedge clk); n++; end
    chk(n <= 19, "R10 latency", n, 19);
    chk(out_valid && out_data == 12'(exp), req, int'(out_data), exp);
    chk(!in_ready, "R8 ready low while result pending", int'(in_ready), 0);
    repeat (hold) @(negedge clk);
    chk(out_valid && out_data == 12'(exp), "R9 hold", int'(out_data), exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R9 release", int'(out_valid), 0);
  endtask

  task automatic run_burst(input int s [7], input bit late_byp, input string req);
    for (int i = 0; i < 6; i++) push(s[i], (i > 0) && late_byp);
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R2 no result after six", int'(out_valid), 0);
    push(s[6], late_byp);
    chk(!in_ready, "R8 ready low after seventh", int'(in_ready), 0);
    collect(ref_mav(s), req, 3);
  endtask

  task automatic t_reset();
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_patterns();
    int up [7]   = '{10, 20, 30, 40, 50, 60, 70};
    int dn [7]   = '{700, 600, 500, 400, 300, 200, 100};
    int spk [7]  = '{100, 4000, 101, 0, 99, 102, 98};
    run_burst(up, 1'b0, "R3 ascending");
    run_burst(dn, 1'b0, "R3 descending");
    run_burst(spk, 1'b0, "R3 spikes rejected");
  endtask

  task automatic t_duplicates();
    int a [7] = '{5, 5, 9, 5, 1, 9, 5};
    int b [7] = '{9, 1, 5, 5, 9, 5, 5};
    int e [7] = '{77, 77, 77, 77, 77, 77, 77};
    run_burst(a, 1'b0, "R4 duplicates order A");
    run_burst(b, 1'b0, "R4 duplicates order B");
    run_burst(e, 1'b0, "R4 all equal");
  endtask

  task automatic t_truncate();
    int a [7] = '{0, 0, 1, 2, 2, 3, 3};  // middle 1,2,2 sum 5 -> 1
    int b [7] = '{0, 1, 1, 1, 2, 9, 9};  // middle 1,1,2 sum 4 -> 1
    run_burst(a, 1'b0, "R5 sum 5 truncates");
    run_burst(b, 1'b0, "R5 sum 4 truncates");
  endtask

  task automatic t_fullscale();
    int a [7] = '{4095, 4095, 4095, 4095, 4095, 4095, 4095};
    int b [7] = '{4095, 0, 4094, 4093, 4095, 1, 4095};
    run_burst(a, 1'b0, "R11 full scale");
    run_burst(b, 1'b0, "R11 near full scale");
  endtask

  task automatic t_bypass();
    push(1234, 1'b1);
    chk(!in_ready, "R6 no more samples taken", int'(in_ready), 0);
    collect(1234, "R6 bypass sample", 2);
    push(4095, 1'b1);
    collect(4095, "R6 bypass full scale", 0);
  endtask

  task automatic t_late_bypass();
    int a [7] = '{300, 100, 900, 500, 700, 200, 800};
    run_burst(a, 1'b1, "R7 late bypass ignored");
  endtask

  task automatic t_random();
    int s [7];
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < 7; i++)
        s[i] = (k % 3 == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 4095));
      run_burst(s, 1'b0, "R3 R5 random burst");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_duplicates();
    t_truncate();
    t_fullscale();
    t_bypass();
    t_late_bypass();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule